// File: doc/BRIEF.md
# Flag Status Bus Sequencer

This block drives a narrow status bus. The bus carries one threshold flag per queue of a device, and up to eight devices share it. Every device has its own instance. An instance shows the flags of all of its queues, whether or not a queue is currently selected for transfers. Two arbitration schemes decide which device owns the shared bus, and a mode input captured during reset picks one of them.

- **Polled mode:** the devices form a ring. A single token circulates around the ring, and whichever device holds the token drives the bus for that clock cycle. A sync output tells the user which cycle belongs to this device.
- **Direct mode:** a strobe selects the owner. With the strobe high, the device-number field of an address bus is compared with each device's identity, and the matching device takes the bus. It keeps the bus until the next strobe.

Real high impedance is not used. Each instance drives a bus-enable output, and a non-owning instance drives all zeros. The same block serves an almost-empty bus by instantiating it on the read clock.

Top module: `flag_bus_seq`

## Requirements
- R1: During reset and in the first cycle after it, an instance whose master input was high during reset owns the bus (`bus_oe_o`=1). Every other instance has `bus_oe_o`=0. The registered flag value reads 0 until the first edge after reset.
- R2: In polled mode, ownership at each rising edge is taken from the token input sampled at that edge. `tok_o` is high in exactly the cycles in which the instance owns the bus. In a ring of three, ownership therefore moves to the next device on every edge.
- R3: In polled mode `sync_o` is high exactly while the instance owns the bus. In direct mode `tok_o` and `sync_o` stay 0.
- R4: A single instance in polled mode, with `tok_o` looped back to `tok_i`, owns the bus and holds `sync_o` high in every cycle.
- R5: In direct mode, a rising edge with `strobe_i`=1 gives ownership to the instance whose identity equals `addr_i[5:3]`. All other instances release the bus. `addr_i[2:0]` has no effect.
- R6: In direct mode, ownership holds while `strobe_i`=0, and `tok_i` has no effect.
- R7: In polled mode, `strobe_i` and `addr_i` have no effect on ownership.
- R8: `bus_o[k]` equals `stat_i[k]` sampled at the previous rising edge, for every lane k up to the configured lane count. The lane count is `qcnt_i`+1, with `qcnt_i` a 2-bit code. Lanes above the configured count read 0.
- R9: When `bus_oe_o`=0, `bus_o` is all zeros, and no two instances on one bus own it in the same cycle.
- R10: Mode, master, identity and lane count are captured only while `rst_n`=0. Changes to these inputs after reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock (write clock for almost-full, read clock for almost-empty) |
| rst_n | input | 1 | Synchronous active-low master reset; configuration captured while low |
| poll_mode_i | input | 1 | 1 = polled ring, 0 = direct strobe selection (captured in reset) |
| master_i | input | 1 | 1 = this device owns the bus first after reset (captured in reset) |
| dev_id_i | input | 3 | Device identity compared in direct mode (captured in reset) |
| qcnt_i | input | 2 | Configured lane count minus one (captured in reset) |
| stat_i | input | 4 | Per-queue threshold flags, lane k = queue k |
| strobe_i | input | 1 | Direct-mode owner-select strobe |
| addr_i | input | 6 | Address bus; bits 5:3 name a device, bits 2:0 ignored here |
| tok_i | input | 1 | Token from the previous device in the ring |
| bus_o | output | 4 | Flag lanes, all zero when not owning |
| bus_oe_o | output | 1 | High while this instance owns the shared bus |
| tok_o | output | 1 | Token to the next device; high while owning in polled mode |
| sync_o | output | 1 | High during this device's polled slot |

## Verification
On every cycle, the embedded assertions check the following:
- In polled mode, ownership follows the token input of the previous edge.
- In direct mode, ownership holds while the strobe is low, and a strobe takes or drops ownership according to the identity match.
- Token and sync stay silent in direct mode, and sync never rises without ownership.
- A non-owning instance presents zeros.
- The captured configuration stays frozen after reset.

Only the bench scenarios can show the system-level behaviour. These cover the rotation order across three connected instances, the absence of double drivers on the resolved bus, the single-device loop, the lane masking of the flag values, and the effect of inputs that change after reset.

// File: rtl/fbs_pkg.sv
// Package: shared types for the flag status bus sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package fbs_pkg;
    // Arbitration scheme selected during reset.
    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_POLLED = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/fbs_cfg_latch.sv
// Module: captures the per-device configuration while reset is held and
// derives the lane mask from the configured lane count.
// Assumes NQ >= 2 so that the count code is at least one bit wide.
module fbs_cfg_latch
    import fbs_pkg::*;
#(
    parameter int NQ   = 4,
    parameter int ID_W = 3,
    localparam int CNT_W = $clog2(NQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_mode_i,
    input  logic [ID_W-1:0]  dev_id_i,
    input  logic [CNT_W-1:0] qcnt_i,
    output bus_mode_e        mode_o,
    output logic [ID_W-1:0]  id_o,
    output logic [NQ-1:0]    mask_o
);
    bus_mode_e        mode_q;
    logic [ID_W-1:0]  id_q;
    logic [CNT_W-1:0] cnt_q;

    // Capture configuration only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= bus_mode_e'(poll_mode_i);
            id_q   <= dev_id_i;
            cnt_q  <= qcnt_i;
        end
    end

    // One enable per lane: active when its index is within the count.
    for (genvar g = 0; g < NQ; g++) begin : g_lane_mask
        assign mask_o[g] = (cnt_q >= CNT_W'(g));
    end

    assign mode_o = mode_q;
    assign id_o   = id_q;

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(mode_q) && $stable(id_q) && $stable(cnt_q)));
endmodule

// File: rtl/fbs_owner.sv
// Module: bus ownership state. Polled mode takes ownership from the ring
// token; direct mode takes it from a strobed identity compare.
// Assumes mode and identity come from the reset-time capture.
module fbs_owner
    import fbs_pkg::*;
#(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bus_mode_e       mode_i,
    input  logic            master_i,
    input  logic [ID_W-1:0] id_i,
    input  logic            strobe_i,
    input  logic [ID_W-1:0] sel_dev_i,
    input  logic            tok_i,
    output logic            own_o
);
    logic own_q;
    logic hit;

    // Identity compare for the strobed selection.
    assign hit = (sel_dev_i == id_i);

    // Ownership update per edge, master owns first after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= master_i;
        end else if (mode_i == MODE_POLLED) begin
            own_q <= tok_i;
        end else if (strobe_i) begin
            own_q <= hit;
        end
    end

    assign own_o = own_q;

    // R2
    poll_follow_tok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_POLLED) |=> (own_q == $past(tok_i)));
    // R5
    strobe_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_DIRECT && strobe_i && sel_dev_i == id_i) |=> own_q);
    // R5
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_DIRECT && strobe_i && sel_dev_i != id_i) |=> !own_q);
    // R6
    direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_DIRECT && !strobe_i) |=> $stable(own_q));
endmodule

// File: rtl/fbs_stat_reg.sv
// Module: registers the per-queue flags each edge, clearing lanes that
// lie above the configured lane count.
// Assumes the mask is stable outside reset.
module fbs_stat_reg #(
    parameter int NQ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NQ-1:0] stat_i,
    input  logic [NQ-1:0] mask_i,
    output logic [NQ-1:0] flags_o
);
    logic [NQ-1:0] flags_q;

    // Sample masked flags every edge; cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= stat_i & mask_i;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/flag_bus_seq.sv
// Module: top of the flag status bus sequencer, one instance per device.
// Drives the shared flag lanes when owning, the token to the next ring
// member and the slot sync pulse. Assumes all instances on one bus share
// the clock and reset, and that ADDR_W > ID_W.
module flag_bus_seq
    import fbs_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 6,
    localparam int CNT_W  = $clog2(NQ),
    localparam int ID_LSB = ADDR_W - ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              poll_mode_i,
    input  logic              master_i,
    input  logic [ID_W-1:0]   dev_id_i,
    input  logic [CNT_W-1:0]  qcnt_i,
    input  logic [NQ-1:0]     stat_i,
    input  logic              strobe_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              tok_i,
    output logic [NQ-1:0]     bus_o,
    output logic              bus_oe_o,
    output logic              tok_o,
    output logic              sync_o
);
    bus_mode_e       mode;
    logic [ID_W-1:0] id;
    logic [NQ-1:0]   mask;
    logic [NQ-1:0]   flags;
    logic            own;
    logic            polled;

    fbs_cfg_latch #(.NQ(NQ), .ID_W(ID_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .poll_mode_i (poll_mode_i),
        .dev_id_i    (dev_id_i),
        .qcnt_i      (qcnt_i),
        .mode_o      (mode),
        .id_o        (id),
        .mask_o      (mask)
    );

    fbs_owner #(.ID_W(ID_W)) u_owner (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .master_i  (master_i),
        .id_i      (id),
        .strobe_i  (strobe_i),
        .sel_dev_i (addr_i[ADDR_W-1:ID_LSB]),
        .tok_i     (tok_i),
        .own_o     (own)
    );

    fbs_stat_reg #(.NQ(NQ)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .stat_i  (stat_i),
        .mask_i  (mask),
        .flags_o (flags)
    );

    // Output stage: lanes only while owning, token and sync only in polled.
    assign polled   = (mode == MODE_POLLED);
    assign bus_oe_o = own;
    assign bus_o    = own ? flags : '0;
    assign tok_o    = own & polled;
    assign sync_o   = own & polled;

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (bus_o == '0));
    // R3
    direct_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !polled |-> (!tok_o && !sync_o));
    // R3
    sync_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> bus_oe_o);
endmodule

// File: tb/test_flag_bus_seq.sv
module test_flag_bus_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int contention = 0;
    bit done = 1'b0;

    // ring configuration inputs
    logic       poll0, poll1, poll2, poll_s;
    logic       mst0, mst1, mst2, mst_s;
    logic [2:0] id0, id1, id2, id_s;
    logic [1:0] qc0, qc1, qc2, qc_s;
    logic [3:0] st0, st1, st2, st_s;
    logic       strobe;
    logic [5:0] addr;
    logic       solo_force;

    logic [3:0] b0, b1, b2, bs;
    logic       oe0, oe1, oe2, oes;
    logic       t0, t1, t2, ts;
    logic       s0, s1, s2, ss;
    logic       solo_tok_in;

    assign solo_tok_in = solo_force ? 1'b1 : ts;

    flag_bus_seq i_flag_bus_seq (.clk(clk), .rst_n(rst_n), .poll_mode_i(poll0),
        .master_i(mst0), .dev_id_i(id0), .qcnt_i(qc0), .stat_i(st0),
        .strobe_i(strobe), .addr_i(addr), .tok_i(t2),
        .bus_o(b0), .bus_oe_o(oe0), .tok_o(t0), .sync_o(s0));
    flag_bus_seq i_dev1 (.clk(clk), .rst_n(rst_n), .poll_mode_i(poll1),
        .master_i(mst1), .dev_id_i(id1), .qcnt_i(qc1), .stat_i(st1),
        .strobe_i(strobe), .addr_i(addr), .tok_i(t0),
        .bus_o(b1), .bus_oe_o(oe1), .tok_o(t1), .sync_o(s1));
    flag_bus_seq i_dev2 (.clk(clk), .rst_n(rst_n), .poll_mode_i(poll2),
        .master_i(mst2), .dev_id_i(id2), .qcnt_i(qc2), .stat_i(st2),
        .strobe_i(strobe), .addr_i(addr), .tok_i(t1),
        .bus_o(b2), .bus_oe_o(oe2), .tok_o(t2), .sync_o(s2));
    flag_bus_seq i_solo (.clk(clk), .rst_n(rst_n), .poll_mode_i(poll_s),
        .master_i(mst_s), .dev_id_i(id_s), .qcnt_i(qc_s), .stat_i(st_s),
        .strobe_i(strobe), .addr_i(addr), .tok_i(solo_tok_in),
        .bus_o(bs), .bus_oe_o(oes), .tok_o(ts), .sync_o(ss));

    // Resolver: shared lanes are the OR of drivers; count double drives.
    logic [3:0] ring_bus;
    assign ring_bus = b0 | b1 | b2;
    always @(negedge clk) begin
        if (rst_n && (int'(oe0) + int'(oe1) + int'(oe2) > 1)) contention++;
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance one edge and settle away from it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic poll, input logic solo_master);
        rst_n = 1'b0;
        poll0 = poll; poll1 = poll; poll2 = poll; poll_s = poll;
        mst0 = 1'b1; mst1 = 1'b0; mst2 = 1'b0; mst_s = solo_master;
        id0 = 3'd5; id1 = 3'd2; id2 = 3'd7; id_s = 3'd0;
        qc0 = 2'd3; qc1 = 2'd3; qc2 = 2'd1; qc_s = 2'd1;
        strobe = 1'b0; addr = '0; solo_force = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b1, 1'b1);
        check("R1", {oe2, oe1, oe0}, 3'b001, "polled owners after reset");
        check("R1", b0, 4'h0, "master flags before first edge");
        check("R9", {b2, b1}, 8'h00, "slave lanes after reset");
        check("R9", contention, 0, "no double drive so far");
    endtask

    task automatic t_poll_rotation();
        st0 = 4'b1010; st1 = 4'b0110; st2 = 4'b1111;
        step();
        check("R2", {oe2, oe1, oe0}, 3'b010, "owner after edge 1");
        check("R2", {t2, t1, t0}, 3'b010, "tokens after edge 1");
        check("R3", {s2, s1, s0}, 3'b010, "sync after edge 1");
        check("R8", ring_bus, 4'b0110, "dev1 flags");
        step();
        check("R2", {oe2, oe1, oe0}, 3'b100, "owner after edge 2");
        check("R8", ring_bus, 4'b0011, "dev2 masked flags");
        step();
        check("R2", {oe2, oe1, oe0}, 3'b001, "owner after edge 3");
        check("R3", {s2, s1, s0}, 3'b001, "sync loop point");
        check("R8", ring_bus, 4'b1010, "dev0 flags");
    endtask

    task automatic t_poll_strobe();
        strobe = 1'b1; addr = {3'd7, 3'b000};
        step();
        strobe = 1'b0;
        check("R7", {oe2, oe1, oe0}, 3'b010, "strobe ignored in polled");
    endtask

    task automatic t_solo();
        st_s = 4'b1111;
        for (int i = 0; i < 4; i++) begin
            step();
            check("R4", {oes, ss, ts}, 3'b111, "solo loop drives with sync");
        end
        check("R8", bs, 4'b0011, "solo lanes above count read 0");
        check("R9", contention, 0, "ring never double driven in polled");
    endtask

    task automatic t_direct();
        do_reset(1'b0, 1'b0);
        solo_force = 1'b1;
        st0 = 4'b1100; st1 = 4'b0101; st2 = 4'b0110;
        check("R1", {oe2, oe1, oe0}, 3'b001, "direct owners after reset");
        check("R3", {t2, t1, t0, s2, s1, s0}, 6'b0, "no token or sync in direct");
        strobe = 1'b1; addr = {3'd2, 3'b111};
        step();
        check("R5", {oe2, oe1, oe0}, 3'b010, "select dev1");
        check("R8", ring_bus, 4'b0101, "dev1 flags in direct");
        addr = {3'd7, 3'b010};
        step();
        check("R5", {oe2, oe1, oe0}, 3'b100, "select dev2, low bits ignored");
        addr = {3'd3, 3'b101};
        step();
        check("R5", {oe2, oe1, oe0}, 3'b000, "unmatched id releases all");
        check("R9", ring_bus, 4'b0000, "no owner gives zero lanes");
        strobe = 1'b0; addr = {3'd5, 3'b000};
        repeat (3) step();
        check("R6", {oe2, oe1, oe0}, 3'b000, "no strobe holds ownership");
        check("R6", oes, 1'b0, "token input ignored in direct");
        strobe = 1'b1;
        step();
        strobe = 1'b0;
        step();
        check("R6", {oe2, oe1, oe0}, 3'b001, "dev0 held after strobe");
        check("R8", ring_bus, 4'b1100, "dev0 flags in direct");
        check("R9", contention, 0, "ring never double driven in direct");
    endtask

    task automatic t_cfg_frozen();
        poll0 = 1'b1; poll1 = 1'b1; poll2 = 1'b1;
        mst1 = 1'b1; id0 = 3'd0; id1 = 3'd5; qc0 = 2'd0;
        step();
        check("R10", {oe2, oe1, oe0}, 3'b001, "mode change ignored");
        check("R10", {t2, t1, t0}, 3'b000, "still direct, no tokens");
        check("R10", b0, 4'b1100, "lane count change ignored");
        strobe = 1'b1; addr = {3'd5, 3'b000};
        step();
        strobe = 1'b0;
        check("R10", {oe2, oe1, oe0}, 3'b001, "identity change ignored");
    endtask

    initial begin
        st0 = '0; st1 = '0; st2 = '0; st_s = '0;
        t_reset();
        t_poll_rotation();
        t_poll_strobe();
        t_solo();
        t_direct();
        t_cfg_frozen();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule